// File: doc/BRIEF.md
# SCSI Transfer Counter and Completion Unit

This block holds the byte counter of a SCSI controller's information-transfer command and decides when that command is finished. Software writes a 16-bit byte count as two bytes through a small register write port. A start strobe then loads the live counter with the effective transfer length. This length is the programmed count, with zero read as 65536, clamped against the magnitude of a signed residual phase length supplied with the start. In command-collection mode it is clamped against a fixed cap instead.

After start, every byte-transferred strobe from the DMA handshake lowers the counter by one and moves the tracked residual toward zero. When the transfer ends, the block posts completion in a single cycle. Completion sets the interrupt and terminal-count status bits, writes the "bus service" code into the interrupt register, zeroes the sequence register, the FIFO-flag register and the counter, and raises the interrupt line. An inbound transfer that empties the phase does not complete on its last byte; it waits for the device's done indication. An interrupt acknowledge lowers the line. The memory side of the DMA transfer is not part of this block.

Top module: `xfer_count_unit`

## Requirements
- R1: After a synchronous reset, status, interrupt, sequence, FIFO-flag and both counter bytes read 0, the residual reads 0, and irq and busy are low.
- R2: reg_sel 0 writes the count's low byte and reg_sel 1 writes its high byte. A programmed count of 0 means 65536 bytes, which shows as counter bytes 0x00/0x00 and reads 0xFFFF after one byte.
- R3: On start the counter loads min(programmed count, |residual|). A negative residual marks a transfer toward the device; zero or positive marks one from the device.
- R4: With cmd_mode high at start, the counter loads min(programmed count, 32) whatever the residual, and the residual does not move during that transfer.
- R5: Start clears status bit 4 (mask 0x10). A register write to reg_sel 0 or 1 also clears it.
- R6: Each byte strobe during a transfer lowers the counter by one, visible the cycle after. Outside cmd_mode the residual goes up by one toward the device and down by one from the device.
- R7: Completion, one cycle after its trigger, ORs 0x90 into status, sets the interrupt register to 0x10, zeroes the sequence register (reg_sel 2), the FIFO-flag register (reg_sel 3) and both counter bytes, raises irq and drops busy.
- R8: Toward the device, or in cmd_mode, completion follows the byte that brings the counter to zero.
- R9: From the device, if the residual is still above zero when the counter reaches zero, completion is immediate. If the residual has reached zero, the unit stays busy until dev_done.
- R10: dev_done during a transfer completes it at once, even with bytes left on the counter.
- R11: A byte strobe while the counter is zero (idle, or waiting for dev_done) changes neither counter nor residual.
- R12: int_ack clears status bit 7 (mask 0x80) and lowers irq, leaving bit 4 as it is.
- R13: A start while a transfer is in progress is ignored.
- R14: A start whose effective length is zero posts completion at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 count low, 1 count high, 2 sequence, 3 FIFO flags |
| reg_wdata | input | 8 | Write data |
| start | input | 1 | Start an information-transfer command |
| cmd_mode | input | 1 | Command-collection mode, sampled at start |
| residual | input | RES_W | Signed residual phase length, sampled at start |
| byte_stb | input | 1 | One byte moved by the DMA handshake |
| dev_done | input | 1 | Device reports the command finished |
| int_ack | input | 1 | Interrupt acknowledge |
| cnt_lo | output | 8 | Live counter, low byte |
| cnt_hi | output | 8 | Live counter, high byte |
| status | output | 8 | Status register (bit 7 interrupt, bit 4 terminal count) |
| intr | output | 8 | Interrupt register |
| seq | output | 8 | Sequence register |
| fifo_flags | output | 8 | FIFO-flag register |
| irq | output | 1 | Interrupt line |
| res_left | output | RES_W | Tracked signed residual |
| busy | output | 1 | Transfer in progress or waiting for dev_done |

## Verification
The bench targets each boundary where the clamp or the completion rule changes its answer.

- **Zero count.** A programmed zero must become 65536 and read 0xFFFF after one byte. A design that treats it as zero would complete at once instead.
- **Clamp limits.** Both the residual limit and the 32-byte command cap are exercised. A wrong clamp loads the wrong counter value, and the error shows on the counter bytes right after start.
- **Inbound completion.** Inbound transfers are tried with data still left and with the phase exhausted. A design that ignores the residual would either raise irq early or stall until dev_done.
- **Ignored inputs.** Strobes while the counter is zero and restarts while busy are checked at the ports: a design that obeyed them would alter the counter or the residual.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RUN  = 2'd1,
        XS_WAIT = 2'd2
    } xfc_state_e;

    typedef enum logic [1:0] {
        RSEL_CNT_LO = 2'd0,
        RSEL_CNT_HI = 2'd1,
        RSEL_SEQ    = 2'd2,
        RSEL_FIFO   = 2'd3
    } xfc_rsel_e;

    typedef struct packed {
        logic to_dev;
        logic cmd;
    } xfc_mode_t;

    localparam logic [7:0] ST_INT_BIT  = 8'h80;
    localparam logic [7:0] ST_TC_BIT   = 8'h10;
    localparam logic [7:0] INTR_DONE   = 8'h10;
    localparam int         CNT_BYTES   = 2;

    function automatic logic is_count_sel(input logic [1:0] sel);
        return (sel == RSEL_CNT_LO) || (sel == RSEL_CNT_HI);
    endfunction

endpackage

// File: rtl/xfc_len_clamp.sv
module xfc_len_clamp #(
    parameter int CNT_W   = 16,
    parameter int RES_W   = 20,
    parameter int CMD_CAP = 32
) (
    input  logic [CNT_W-1:0]        prog,
    input  logic signed [RES_W-1:0] res,
    input  logic                    cmd_mode,
    output logic [CNT_W:0]          eff,
    output logic                    to_dev
);
    localparam int LEN_W = CNT_W + 1;
    localparam int CW    = (RES_W > LEN_W) ? RES_W : LEN_W;

    logic [LEN_W-1:0] prog_full;
    logic [RES_W-1:0] mag;
    logic [CW-1:0]    lim_a;
    logic [CW-1:0]    lim_b;

    always_comb begin
        prog_full = (prog == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, prog};
        to_dev    = res[RES_W-1];
        mag       = to_dev ? RES_W'(-res) : RES_W'(res);
        lim_a     = CW'(prog_full);
        lim_b     = cmd_mode ? CW'(CMD_CAP) : CW'(mag);
        eff       = (lim_a < lim_b) ? LEN_W'(lim_a) : LEN_W'(lim_b);
    end
endmodule

// File: rtl/xfc_down_counter.sv
module xfc_down_counter #(
    parameter int LEN_W = 17,
    parameter int RES_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [LEN_W-1:0]        load_len,
    input  logic signed [RES_W-1:0] load_res,
    input  logic                    dec,
    input  logic                    res_step,
    input  logic                    to_dev,
    input  logic                    clear,
    output logic [LEN_W-1:0]        count,
    output logic signed [RES_W-1:0] res_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (load) begin
            count <= load_len;
        end else if (dec) begin
            count <= count - LEN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (load) begin
            res_q <= load_res;
        end else if (dec && res_step) begin
            res_q <= to_dev ? res_q + RES_W'(1) : res_q - RES_W'(1);
        end
    end

    assert_dec_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
        dec |-> count != '0);

    assert_dec_step_R6: assert property (@(posedge clk) disable iff (rst)
        (dec && !clear && !load) |=> count == $past(count) - LEN_W'(1));
endmodule

// File: rtl/xfc_ctrl.sv
module xfc_ctrl #(
    parameter int LEN_W = 17,
    parameter int RES_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    byte_stb,
    input  logic                    dev_done,
    input  logic                    cmd_mode,
    input  logic                    to_dev,
    input  logic                    eff_zero,
    input  logic                    count_last,
    input  logic signed [RES_W-1:0] res_q,
    output logic                    load,
    output logic                    dec,
    output logic                    res_step,
    output logic                    post_done,
    output logic                    busy,
    output logic                    dir_q
);
    import xfc_pkg::*;

    localparam logic signed [RES_W-1:0] RES_ONE = RES_W'(1);

    xfc_state_e state, nxt;
    xfc_mode_t  mode_q;

    always_comb begin
        nxt       = state;
        load      = 1'b0;
        dec       = 1'b0;
        post_done = 1'b0;
        unique case (state)
            XS_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (eff_zero) post_done = 1'b1;
                    else          nxt = XS_RUN;
                end
            end
            XS_RUN: begin
                if (dev_done) begin
                    post_done = 1'b1;
                    nxt       = XS_IDLE;
                end else if (byte_stb) begin
                    dec = 1'b1;
                    if (count_last) begin
                        if (mode_q.to_dev || mode_q.cmd || (res_q > RES_ONE)) begin
                            post_done = 1'b1;
                            nxt       = XS_IDLE;
                        end else begin
                            nxt = XS_WAIT;
                        end
                    end
                end
            end
            XS_WAIT: begin
                if (dev_done) begin
                    post_done = 1'b1;
                    nxt       = XS_IDLE;
                end
            end
            default: nxt = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= XS_IDLE;
            mode_q <= '0;
        end else begin
            state <= nxt;
            if (load) begin
                mode_q.to_dev <= to_dev;
                mode_q.cmd    <= cmd_mode;
            end
        end
    end

    assign busy     = (state != XS_IDLE);
    assign res_step = !mode_q.cmd;
    assign dir_q    = mode_q.to_dev;

    assert_wait_inbound_R9: assert property (@(posedge clk) disable iff (rst)
        (state == XS_WAIT) |-> (!mode_q.to_dev && !mode_q.cmd));

    assert_restart_ignored_R13: assert property (@(posedge clk) disable iff (rst)
        (state == XS_RUN && start && !byte_stb && !dev_done) |=> state == XS_RUN);
endmodule

// File: rtl/xfc_status_regs.sv
module xfc_status_regs (
    input  logic       clk,
    input  logic       rst,
    input  logic       post_done,
    input  logic       tc_clr,
    input  logic       int_ack,
    input  logic       seq_we,
    input  logic       fifo_we,
    input  logic [7:0] wdata,
    output logic [7:0] status,
    output logic [7:0] intr,
    output logic [7:0] seq,
    output logic [7:0] fifo_flags,
    output logic       irq
);
    import xfc_pkg::*;

    logic [7:0] status_nxt;

    always_comb begin
        status_nxt = status;
        if (post_done) begin
            status_nxt = status | ST_INT_BIT | ST_TC_BIT;
        end else begin
            if (tc_clr)  status_nxt = status_nxt & ~ST_TC_BIT;
            if (int_ack) status_nxt = status_nxt & ~ST_INT_BIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status     <= '0;
            intr       <= '0;
            seq        <= '0;
            fifo_flags <= '0;
            irq        <= 1'b0;
        end else begin
            status <= status_nxt;
            if (post_done) begin
                intr       <= INTR_DONE;
                seq        <= '0;
                fifo_flags <= '0;
                irq        <= 1'b1;
            end else begin
                if (seq_we)  seq        <= wdata;
                if (fifo_we) fifo_flags <= wdata;
                if (int_ack) irq        <= 1'b0;
            end
        end
    end

    assert_post_regs_R7: assert property (@(posedge clk) disable iff (rst)
        post_done |=> (status[7] && status[4] && intr == INTR_DONE && irq
                       && seq == '0 && fifo_flags == '0));

    assert_ack_clears_R12: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !post_done) |=> (!irq && !status[7]));

    assert_tc_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (tc_clr && !post_done) |=> !status[4]);
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
    parameter int RES_W   = 20,
    parameter int CMD_CAP = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_we,
    input  logic [1:0]              reg_sel,
    input  logic [7:0]              reg_wdata,
    input  logic                    start,
    input  logic                    cmd_mode,
    input  logic signed [RES_W-1:0] residual,
    input  logic                    byte_stb,
    input  logic                    dev_done,
    input  logic                    int_ack,
    output logic [7:0]              cnt_lo,
    output logic [7:0]              cnt_hi,
    output logic [7:0]              status,
    output logic [7:0]              intr,
    output logic [7:0]              seq,
    output logic [7:0]              fifo_flags,
    output logic                    irq,
    output logic signed [RES_W-1:0] res_left,
    output logic                    busy
);
    import xfc_pkg::*;

    localparam int CNT_W = 8 * CNT_BYTES;
    localparam int LEN_W = CNT_W + 1;

    logic [7:0]       prog_byte [CNT_BYTES];
    logic [CNT_W-1:0] prog;
    logic [LEN_W-1:0] eff;
    logic [LEN_W-1:0] count;
    logic             to_dev, dir_q;
    logic             load, dec, res_step, post_done;
    logic             tc_clr;

    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_prog
        always_ff @(posedge clk) begin
            if (rst) begin
                prog_byte[b] <= '0;
            end else if (reg_we && reg_sel == 2'(b)) begin
                prog_byte[b] <= reg_wdata;
            end
        end
        assign prog[8*b +: 8] = prog_byte[b];
    end

    assign tc_clr = start || (reg_we && is_count_sel(reg_sel));

    xfc_len_clamp #(.CNT_W(CNT_W), .RES_W(RES_W), .CMD_CAP(CMD_CAP)) u_clamp (
        .prog     (prog),
        .res      (residual),
        .cmd_mode (cmd_mode),
        .eff      (eff),
        .to_dev   (to_dev)
    );

    xfc_ctrl #(.LEN_W(LEN_W), .RES_W(RES_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .byte_stb   (byte_stb),
        .dev_done   (dev_done),
        .cmd_mode   (cmd_mode),
        .to_dev     (to_dev),
        .eff_zero   (eff == '0),
        .count_last (count == LEN_W'(1)),
        .res_q      (res_left),
        .load       (load),
        .dec        (dec),
        .res_step   (res_step),
        .post_done  (post_done),
        .busy       (busy),
        .dir_q      (dir_q)
    );

    xfc_down_counter #(.LEN_W(LEN_W), .RES_W(RES_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_len (eff),
        .load_res (residual),
        .dec      (dec),
        .res_step (res_step),
        .to_dev   (dir_q),
        .clear    (post_done),
        .count    (count),
        .res_q    (res_left)
    );

    xfc_status_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .post_done  (post_done),
        .tc_clr     (tc_clr),
        .int_ack    (int_ack),
        .seq_we     (reg_we && reg_sel == RSEL_SEQ),
        .fifo_we    (reg_we && reg_sel == RSEL_FIFO),
        .wdata      (reg_wdata),
        .status     (status),
        .intr       (intr),
        .seq        (seq),
        .fifo_flags (fifo_flags),
        .irq        (irq)
    );

    assign cnt_lo = count[7:0];
    assign cnt_hi = count[15:8];

    assert_done_zeroes_count_R7: assert property (@(posedge clk) disable iff (rst)
        post_done |=> (cnt_lo == 8'h00 && cnt_hi == 8'h00 && !busy));

    assert_irq_has_status_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> status[7]);
endmodule

// File: tb/xfer_count_unit_bench.sv
module xfer_count_unit_bench;
    localparam int RES_W = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic start = 1'b0, cmd_mode = 1'b0, byte_stb = 1'b0, dev_done = 1'b0, int_ack = 1'b0;
    logic signed [RES_W-1:0] residual = '0;
    logic [7:0] cnt_lo, cnt_hi, status, intr, seq, fifo_flags;
    logic irq, busy;
    logic signed [RES_W-1:0] res_left;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xfer_count_unit #(.RES_W(RES_W)) u_xfer_count_unit (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .start(start), .cmd_mode(cmd_mode), .residual(residual), .byte_stb(byte_stb),
        .dev_done(dev_done), .int_ack(int_ack), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .status(status), .intr(intr), .seq(seq), .fifo_flags(fifo_flags), .irq(irq),
        .res_left(res_left), .busy(busy)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int cnt16();
        return {cnt_hi, cnt_lo};
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic go(input int res, input logic cmd);
        residual = RES_W'(res); cmd_mode = cmd; start = 1'b1;
        tick();
        start = 1'b0; cmd_mode = 1'b0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            byte_stb = 1'b1;
            tick();
        end
        byte_stb = 1'b0;
    endtask

    task automatic pulse_done();
        dev_done = 1'b1; tick(); dev_done = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1; tick(); int_ack = 1'b0;
    endtask

    task automatic expect_done(input string req);
        chk({req, " status"}, status, 8'h90);
        chk({req, " intr"}, intr, 8'h10);
        chk({req, " irq"}, irq, 1);
        chk({req, " busy"}, busy, 0);
        chk({req, " count"}, cnt16(), 0);
    endtask

    task automatic t_reset();
        chk("R1 status", status, 0);
        chk("R1 intr", intr, 0);
        chk("R1 seq", seq, 0);
        chk("R1 fifo", fifo_flags, 0);
        chk("R1 count", cnt16(), 0);
        chk("R1 residual", int'(res_left), 0);
        chk("R1 irq", irq, 0);
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_outbound();
        wr(2'd0, 8'd5); wr(2'd1, 8'd0);
        wr(2'd2, 8'h04); wr(2'd3, 8'h07);
        go(-3, 1'b0);
        chk("R3 clamp to residual", cnt16(), 3);
        chk("R3 busy", busy, 1);
        strobe(1);
        chk("R6 count step", cnt16(), 2);
        chk("R6 residual toward device", int'(res_left), -2);
        strobe(1);
        chk("R8 not yet done", irq, 0);
        strobe(1);
        expect_done("R7 R8");
        chk("R7 seq zeroed", seq, 0);
        chk("R7 fifo zeroed", fifo_flags, 0);
        chk("R6 residual end", int'(res_left), 0);
    endtask

    task automatic t_ack();
        ack();
        chk("R12 status after ack", status, 8'h10);
        chk("R12 irq after ack", irq, 0);
    endtask

    task automatic t_prog_limit();
        wr(2'd0, 8'h34); wr(2'd1, 8'h12);
        chk("R5 count write clears TC", status, 8'h00);
        go(100000, 1'b0);
        chk("R2 R3 count lo", cnt_lo, 8'h34);
        chk("R2 R3 count hi", cnt_hi, 8'h12);
        strobe(2);
        chk("R6 residual from device", int'(res_left), 99998);
        pulse_done();
        expect_done("R10");
        chk("R10 residual kept", int'(res_left), 99998);
        ack();
    endtask

    task automatic t_zero_count();
        wr(2'd0, 8'd0); wr(2'd1, 8'd0);
        go(70000, 1'b0);
        chk("R2 zero count shows 0", cnt16(), 0);
        chk("R2 zero count busy", busy, 1);
        strobe(1);
        chk("R2 65536 minus one", cnt16(), 16'hFFFF);
        pulse_done();
        expect_done("R2 R10");
        ack();
    endtask

    task automatic t_cmd_cap();
        wr(2'd0, 8'h40); wr(2'd1, 8'd0);
        go(0, 1'b1);
        chk("R4 cmd cap", cnt16(), 32);
        strobe(31);
        chk("R4 one left", cnt16(), 1);
        chk("R4 residual held", int'(res_left), 0);
        strobe(1);
        expect_done("R4 R8");
        ack();
    endtask

    task automatic t_in_more();
        wr(2'd0, 8'd4); wr(2'd1, 8'd0);
        go(10, 1'b0);
        strobe(4);
        expect_done("R9 data remains");
        chk("R9 residual", int'(res_left), 6);
        ack();
    endtask

    task automatic t_in_wait();
        wr(2'd0, 8'd8); wr(2'd1, 8'd0);
        go(3, 1'b0);
        strobe(3);
        chk("R9 waits busy", busy, 1);
        chk("R9 waits no irq", irq, 0);
        chk("R9 count zero", cnt16(), 0);
        strobe(1);
        chk("R11 waiting strobe count", cnt16(), 0);
        chk("R11 waiting strobe residual", int'(res_left), 0);
        pulse_done();
        expect_done("R9 dev_done");
        ack();
    endtask

    task automatic t_idle_strobe();
        strobe(2);
        chk("R11 idle strobe count", cnt16(), 0);
        chk("R11 idle strobe residual", int'(res_left), 0);
    endtask

    task automatic t_busy_start();
        wr(2'd0, 8'd10); wr(2'd1, 8'd0);
        go(-10, 1'b0);
        chk("R5 start clears TC", status, 8'h00);
        strobe(1);
        wr(2'd0, 8'd3);
        go(-50, 1'b0);
        chk("R13 restart ignored count", cnt16(), 9);
        chk("R13 restart ignored residual", int'(res_left), -9);
        pulse_done();
        expect_done("R13 end");
        ack();
    endtask

    task automatic t_zero_eff();
        wr(2'd0, 8'd5); wr(2'd1, 8'd0);
        go(0, 1'b0);
        expect_done("R14");
        ack();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all R): actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_outbound();
        t_ack();
        t_prog_limit();
        t_zero_count();
        t_cmd_cap();
        t_in_more();
        t_in_wait();
        t_idle_strobe();
        t_busy_start();
        t_zero_eff();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule